// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Chain

This block holds the digital counters of one phase-locked-loop synthesizer channel. A reference divider counts cycles of the crystal oscillator clock and produces the comparison pulse for the phase detector. A feedback divider counts cycles of a dual-modulus prescaler's output. It steers that prescaler through a modulus-control output, so that the whole loop divides the VCO by a programmed N. This is done by pulse swallowing: N is split into a swallow count A and a main count B, and the prescaler divides by P+1 for A of every B prescaler cycles and by P for the rest.

Each divider emits a one-clock pulse at its terminal count and reloads at once. A new divide value is taken up only at the next terminal count, so no period is ever cut short or stretched by a write. Powering the channel down stops its feedback side. The reference divider is shared with the companion channel and stops only when both channels are powered down. A counter-reset request holds every counter at zero. On release, both dividers start together, and the feedback side's first edge comes within one prescaler cycle of the reference side's.

Top module: `syn_div_chain`

## Requirements
- R1: While `rst_n` is low, `ref_pulse`, `fb_pulse` and `mod_ctl` are all low.
- R2: With a reference value R (R ≥ 2), `ref_pulse` rises every R cycles of `ref_clk` and stays high for exactly one `ref_clk` cycle. With R ≥ 5 and a 50 MHz `ref_clk`, the pulse interval is at least 100 ns, which keeps the comparison rate at or below 10 MHz.
- R3: The feedback value splits into A = N mod P (the low log2(P) bits) and B = N / P (the remaining upper bits), with B ≥ 2 and B ≥ A. `fb_pulse` rises every B rising edges of `pre_clk` and stays high for one `pre_clk` cycle.
- R4: Within every feedback period, `mod_ctl` is high for exactly A of the B prescaler cycles. A prescaler that divides by P+1 while `mod_ctl` is high and by P otherwise therefore spends exactly N VCO cycles per `fb_pulse` period.
- R5: `pair_hi` = 0 selects P = 2^PLG and `pair_hi` = 1 selects P = 2^(PLG+1). With the default PLG = 5 these are 32/33 and 64/65, and the choice moves the A/B split point by one bit.
- R6: A change of `r_word` or `n_word` in mid-period does not alter the period in progress. The new value governs the period that starts at the next terminal count.
- R7: While `pd_self` is high, `fb_pulse` stays low, and `mod_ctl` is low from the next `pre_clk` edge on. If `pd_other` is low, `ref_pulse` keeps running.
- R8: While `pd_self` and `pd_other` are both high, `ref_pulse` stays low.
- R9: While `cnt_rst` is high, both pulse outputs stay low. After release, the first `ref_pulse` rises on the R-th `ref_clk` edge and the first `fb_pulse` on the B-th `pre_clk` edge after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Oscillator clock counted by the reference divider |
| pre_clk | input | 1 | Prescaler output clock counted by the feedback divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_word | input | NW | Feedback divide value N (swallow bits low, main bits high) |
| r_word | input | RW | Reference divide value R |
| pair_hi | input | 1 | Prescaler modulus pair select: 0 small pair, 1 large pair |
| pd_self | input | 1 | Powerdown of this channel |
| pd_other | input | 1 | Powerdown of the companion channel |
| cnt_rst | input | 1 | Counter reset request, holds all counters at zero |
| ref_pulse | output | 1 | One-cycle reference comparison pulse |
| fb_pulse | output | 1 | One-cycle divided feedback pulse |
| mod_ctl | output | 1 | Modulus control: high requests divide by P+1 |

## Verification
A wrong count or a bad reload shows up as a change in the interval between successive `ref_pulse` or `fb_pulse` edges. The error appears within one period and persists, so the interval is measured in edges of the clock being divided. A wrong swallow count leaves the `fb_pulse` edge spacing correct. It is caught only by counting VCO cycles through a modelled prescaler, or by counting the prescaler cycles with `mod_ctl` high, over one whole feedback period. Gating faults in the powerdown and counter-reset logic are seen within one clock as stray pulses while a hold is active. They are also seen as a first post-release pulse on the wrong edge.

// File: rtl/syn_div_pkg.sv
`timescale 1ns/1ps
package syn_div_pkg;

  typedef enum logic {
    PAIR_SMALL = 1'b0,
    PAIR_LARGE = 1'b1
  } pair_sel_e;

  // log2 of the prescaler's base modulus for the selected pair
  function automatic int unsigned pre_log2(input int unsigned lg_small, input pair_sel_e sel);
    return lg_small + ((sel == PAIR_LARGE) ? 32'd1 : 32'd0);
  endfunction

  // swallow count: cycles per period spent dividing by P+1
  function automatic logic [31:0] swallow_of(input logic [31:0] n, input int unsigned lg);
    return n & ((32'd1 << lg) - 32'd1);
  endfunction

  // main count: prescaler cycles per feedback period
  function automatic logic [31:0] main_of(input logic [31:0] n, input int unsigned lg);
    return n >> lg;
  endfunction

endpackage

// File: rtl/syn_tc_counter.sv
`timescale 1ns/1ps
module syn_tc_counter #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] lim_in,
  output logic [W-1:0] count,
  output logic         load,
  output logic         pulse
);

  logic [W-1:0] lim_q;
  logic         fresh_q;
  logic         at_end;

  // terminal count: last state of the running period
  assign at_end = !fresh_q && (count == lim_q - W'(1));
  // the limit is captured only at a period boundary or while held
  assign load   = hold || fresh_q || at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      lim_q   <= '0;
      fresh_q <= 1'b1;
      pulse   <= 1'b0;
    end else begin
      fresh_q <= 1'b0;
      pulse   <= at_end && !hold;
      if (load) begin
        count <= '0;
        lim_q <= lim_in;
      end else begin
        count <= count + W'(1);
      end
    end
  end

endmodule

// File: rtl/syn_swallow_ctr.sv
`timescale 1ns/1ps
module syn_swallow_ctr
  import syn_div_pkg::*;
#(
  parameter int NW  = 18,
  parameter int PLG = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [NW-1:0] n_cfg,
  input  pair_sel_e     pair,
  output logic          mod_raw,
  output logic          fb_pulse,
  output logic          fb_load,
  output logic [NW-PLG-1:0] fb_cnt
);

  localparam int AW = PLG + 1;
  localparam int BW = NW - PLG;

  int unsigned   lg;
  logic [31:0]   n_ext;
  logic [AW-1:0] a_nx;
  logic [BW-1:0] b_nx;
  logic [AW-1:0] a_q;

  assign lg    = pre_log2(PLG, pair);
  assign n_ext = 32'(n_cfg);
  assign a_nx  = AW'(swallow_of(n_ext, lg));
  assign b_nx  = BW'(main_of(n_ext, lg));

  syn_tc_counter #(.W(BW)) u_main (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .lim_in (b_nx),
    .count  (fb_cnt),
    .load   (fb_load),
    .pulse  (fb_pulse)
  );

  // swallow count captured together with the main count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       a_q <= '0;
    else if (fb_load) a_q <= a_nx;
  end

  // first A prescaler cycles of each period request P+1
  assign mod_raw = BW'(a_q) > fb_cnt;

endmodule

// File: rtl/syn_div_chain.sv
`timescale 1ns/1ps
module syn_div_chain
  import syn_div_pkg::*;
#(
  parameter int NW  = 18,
  parameter int RW  = 15,
  parameter int PLG = 5
) (
  input  logic          ref_clk,
  input  logic          pre_clk,
  input  logic          rst_n,
  input  logic [NW-1:0] n_word,
  input  logic [RW-1:0] r_word,
  input  logic          pair_hi,
  input  logic          pd_self,
  input  logic          pd_other,
  input  logic          cnt_rst,
  output logic          ref_pulse,
  output logic          fb_pulse,
  output logic          mod_ctl
);

  localparam int BW = NW - PLG;

  logic          ref_hold;
  logic          fb_hold;
  logic          ref_load;
  logic          fb_load;
  logic [RW-1:0] ref_cnt;
  logic [BW-1:0] fb_cnt;
  logic          mod_raw;
  logic          n_run_q;

  // shared reference side stops only when both channels sleep
  assign ref_hold = cnt_rst || (pd_self && pd_other);
  assign fb_hold  = cnt_rst || pd_self;

  syn_tc_counter #(.W(RW)) u_ref (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .hold   (ref_hold),
    .lim_in (r_word),
    .count  (ref_cnt),
    .load   (ref_load),
    .pulse  (ref_pulse)
  );

  syn_swallow_ctr #(.NW(NW), .PLG(PLG)) u_fb (
    .clk      (pre_clk),
    .rst_n    (rst_n),
    .hold     (fb_hold),
    .n_cfg    (n_word),
    .pair     (pair_sel_e'(pair_hi)),
    .mod_raw  (mod_raw),
    .fb_pulse (fb_pulse),
    .fb_load  (fb_load),
    .fb_cnt   (fb_cnt)
  );

  always_ff @(posedge pre_clk or negedge rst_n) begin
    if (!rst_n) n_run_q <= 1'b0;
    else        n_run_q <= !pd_self;
  end

  assign mod_ctl = n_run_q && mod_raw;

endmodule

// File: rtl/syn_div_chain_chk.sv
`timescale 1ns/1ps
module syn_div_chain_chk #(
  parameter int RW = 15,
  parameter int BW = 13
) (
  input logic          ref_clk,
  input logic          pre_clk,
  input logic          rst_n,
  input logic          pd_self,
  input logic          pd_other,
  input logic          cnt_rst,
  input logic          ref_pulse,
  input logic          fb_pulse,
  input logic          mod_ctl,
  input logic          ref_load,
  input logic          fb_load,
  input logic [RW-1:0] ref_cnt,
  input logic [BW-1:0] fb_cnt
);

  // R2
  ref_one_clk_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  // R2
  ref_at_zero_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |-> (ref_cnt == '0));

  // R3
  fb_one_clk_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  // R3
  fb_at_zero_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
    fb_pulse |-> (fb_cnt == '0));

  // R6
  ref_reload_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |-> $past(ref_load));

  // R6
  fb_reload_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
    fb_pulse |-> $past(fb_load));

  // R7
  fb_quiet_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
    (pd_self || cnt_rst) |=> !fb_pulse);

  // R7
  mod_off_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
    pd_self |=> !mod_ctl);

  // R8
  ref_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cnt_rst || (pd_self && pd_other)) |=> !ref_pulse);

endmodule

bind syn_div_chain syn_div_chain_chk #(.RW(RW), .BW(NW - PLG)) u_chk (
  .ref_clk   (ref_clk),
  .pre_clk   (pre_clk),
  .rst_n     (rst_n),
  .pd_self   (pd_self),
  .pd_other  (pd_other),
  .cnt_rst   (cnt_rst),
  .ref_pulse (ref_pulse),
  .fb_pulse  (fb_pulse),
  .mod_ctl   (mod_ctl),
  .ref_load  (ref_load),
  .fb_load   (fb_load),
  .ref_cnt   (ref_cnt),
  .fb_cnt    (fb_cnt)
);

// File: tb/sim_syn_div_chain.sv
`timescale 1ns/1ps
module sim_syn_div_chain;

  localparam int NW  = 18;
  localparam int RW  = 15;
  localparam int PLG = 5;
  localparam int PSM = 1 << PLG;

  logic          ref_clk = 1'b0;
  logic          vco_clk = 1'b0;
  logic          pre_clk = 1'b0;
  logic          rst_n   = 1'b1;
  logic [NW-1:0] n_word  = '0;
  logic [RW-1:0] r_word  = '0;
  logic          pair_hi = 1'b0;
  logic          pd_self = 1'b0;
  logic          pd_other = 1'b0;
  logic          cnt_rst = 1'b0;
  logic          ref_pulse, fb_pulse, mod_ctl;

  int checks = 0, fails = 0;
  int rcount = 0, pcount = 0, vcount = 0, mcount = 0;
  int nref = 0, nfb = 0, nmod = 0;
  int pcnt = 0;

  syn_div_chain #(.NW(NW), .RW(RW), .PLG(PLG)) u0 (
    .ref_clk(ref_clk), .pre_clk(pre_clk), .rst_n(rst_n),
    .n_word(n_word), .r_word(r_word), .pair_hi(pair_hi),
    .pd_self(pd_self), .pd_other(pd_other), .cnt_rst(cnt_rst),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .mod_ctl(mod_ctl)
  );

  always #10 ref_clk = ~ref_clk;
  always #1  vco_clk = ~vco_clk;

  // behavioural dual-modulus prescaler: divides by P or P+1
  always @(posedge vco_clk) begin
    vcount <= vcount + 1;
    if (pcnt == 0) begin
      pcnt    <= (mod_ctl ? ((pair_hi ? 2*PSM : PSM) + 1) : (pair_hi ? 2*PSM : PSM)) - 1;
      if (mod_ctl) mcount <= mcount + 1;
      pre_clk <= 1'b1;
    end else begin
      pcnt    <= pcnt - 1;
      pre_clk <= 1'b0;
    end
  end

  always @(posedge pre_clk) pcount <= pcount + 1;
  always @(posedge ref_clk) rcount <= rcount + 1;
  always @(posedge ref_pulse) nref = nref + 1;
  always @(posedge fb_pulse)  nfb  = nfb + 1;
  always @(posedge mod_ctl)   nmod = nmod + 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fb_period(output int dp, output int dv, output int dm);
    int p0, v0, m0;
    @(posedge fb_pulse); #0.5;
    p0 = pcount; v0 = vcount; m0 = mcount;
    @(posedge fb_pulse); #0.5;
    dp = pcount - p0; dv = vcount - v0; dm = mcount - m0;
  endtask

  task automatic ref_period(output int dr, output realtime dt);
    int r0; realtime t0;
    @(posedge ref_pulse); #0.5;
    r0 = rcount; t0 = $realtime;
    @(posedge ref_pulse); #0.5;
    dr = rcount - r0; dt = $realtime - t0;
  endtask

  task automatic t_reset();
    n_word = NW'(6*PSM + 3);
    r_word = RW'(10);
    #2 rst_n = 1'b0;
    #3;
    chk("R1 ref_pulse in reset", ref_pulse, 0);
    chk("R1 fb_pulse in reset", fb_pulse, 0);
    chk("R1 mod_ctl in reset", mod_ctl, 0);
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
  endtask

  task automatic t_ref_div();
    int dr; realtime dt;
    ref_period(dr, dt);
    ref_period(dr, dt);
    chk("R2 ref period R=10", dr, 10);
    @(posedge ref_pulse);
    @(posedge ref_clk); #1;
    chk("R2 ref width one cycle", ref_pulse, 0);
    r_word = RW'(5);
    ref_period(dr, dt);
    ref_period(dr, dt);
    chk("R2 ref period R=5", dr, 5);
    chk("R2 ref interval >= 100ns", (dt >= 100.0) ? 1 : 0, 1);
    r_word = RW'(10);
    ref_period(dr, dt);
  endtask

  task automatic t_fb_div();
    int dp, dv, dm;
    fb_period(dp, dv, dm);
    fb_period(dp, dv, dm);
    chk("R3 fb period B=6 prescaler edges", dp, 6);
    chk("R4 vco cycles per period N=195", dv, 6*PSM + 3);
    chk("R4 mod_ctl high cycles A=3", dm, 3);
    @(posedge fb_pulse);
    @(posedge pre_clk); #1;
    chk("R3 fb width one prescaler cycle", fb_pulse, 0);
  endtask

  task automatic t_pair();
    int dp, dv, dm;
    pair_hi = 1'b1;
    n_word  = NW'(7*2*PSM + 4);
    fb_period(dp, dv, dm);
    fb_period(dp, dv, dm);
    chk("R5 large pair B=7", dp, 7);
    chk("R5 large pair N=452", dv, 452);
    chk("R5 large pair A=4", dm, 4);
    pair_hi = 1'b0;
    fb_period(dp, dv, dm);
    fb_period(dp, dv, dm);
    chk("R5 small pair same word B=14", dp, 14);
    chk("R5 small pair same word N=452", dv, 452);
    chk("R5 small pair same word A=4", dm, 4);
  endtask

  task automatic t_retime();
    int p0, p1, p2, r0, r1, r2;
    n_word = NW'(6*PSM + 3);
    repeat (3) @(posedge fb_pulse);
    #0.5 p0 = pcount;
    @(posedge pre_clk); @(posedge pre_clk); #0.5;
    n_word = NW'(9*PSM + 1);
    @(posedge fb_pulse); #0.5 p1 = pcount;
    @(posedge fb_pulse); #0.5 p2 = pcount;
    chk("R6 fb period in progress keeps B=6", p1 - p0, 6);
    chk("R6 fb next period uses B=9", p2 - p1, 9);
    @(posedge ref_pulse); #0.5 r0 = rcount;
    repeat (2) @(negedge ref_clk);
    r_word = RW'(7);
    @(posedge ref_pulse); #0.5 r1 = rcount;
    @(posedge ref_pulse); #0.5 r2 = rcount;
    chk("R6 ref period in progress keeps R=10", r1 - r0, 10);
    chk("R6 ref next period uses R=7", r2 - r1, 7);
  endtask

  task automatic t_powerdown();
    int f0, m0, r0;
    @(negedge ref_clk) pd_self = 1'b1;
    #300;
    f0 = nfb; m0 = nmod; r0 = nref;
    #3000;
    chk("R7 no fb pulses while powered down", nfb - f0, 0);
    chk("R7 no mod_ctl rise while powered down", nmod - m0, 0);
    chk("R7 mod_ctl low while powered down", mod_ctl, 0);
    chk("R7 ref keeps running", (nref - r0 > 10) ? 1 : 0, 1);
    @(negedge ref_clk) pd_other = 1'b1;
    #300;
    r0 = nref;
    #3000;
    chk("R8 no ref pulses with both down", nref - r0, 0);
    chk("R8 ref_pulse low with both down", ref_pulse, 0);
    @(negedge ref_clk);
    pd_self = 1'b0;
    pd_other = 1'b0;
  endtask

  task automatic t_cnt_rst();
    int r0, f0, rstart, pstart, dr, dpp;
    r_word  = RW'(8);
    n_word  = NW'(6*PSM + 2);
    repeat (3) @(posedge fb_pulse);
    @(negedge ref_clk) cnt_rst = 1'b1;
    repeat (5) @(negedge ref_clk);
    r0 = nref; f0 = nfb;
    repeat (20) @(negedge ref_clk);
    chk("R9 no ref pulses during counter reset", nref - r0, 0);
    chk("R9 no fb pulses during counter reset", nfb - f0, 0);
    cnt_rst = 1'b0;
    rstart = rcount; pstart = pcount;
    dr = 0; dpp = 0;
    fork
      begin @(posedge ref_pulse); #0.5 dr = rcount - rstart; end
      begin @(posedge fb_pulse);  #0.5 dpp = pcount - pstart; end
    join
    chk("R9 first ref pulse on edge R=8", dr, 8);
    chk("R9 first fb pulse on prescaler edge B=6", dpp, 6);
  endtask

  initial begin
    t_reset();
    t_ref_div();
    t_fb_div();
    t_pair();
    t_retime();
    t_powerdown();
    t_cnt_rst();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule